// File: doc/BRIEF.md
# Hash Message Padding Front-End

This block sits in front of a hash compression engine. Software streams a message into it as 32-bit words over a valid/ready write port. The words pass through a small FIFO and are gathered into 512-bit blocks, which go out on a block_valid/block_ready port. When the message is complete, software raises a one-cycle "go" strobe. With the strobe it supplies the number of valid bits in the final word and the length-field byte order. The block then finishes the message in hardware. It places a single one bit directly after the last message bit, fills with zeros up to 448 bits modulo 512, and writes the 64-bit message bit length into the last two words of the final block.

If the one bit lands so close to the end of a block that the length no longer fits, two blocks are emitted. The first is zero-filled and the second holds only padding and the length. A running 64-bit bit counter tracks the message length. A full block is kept back until the block knows whether the message goes on, so that the final word can still be trimmed and marked. After the last block is taken, the counter and control state clear and a new message may begin.

Top module: `hash_pad_frontend`

## Requirements
- R1: An output block is 16 words of 32 bits. Word 0 occupies blk_data[511:480] and word 15 occupies blk_data[31:0]. Within a word, bit 31 comes first in the stream. Message words appear unchanged and in arrival order, and every block except the final one has blk_last = 0.
- R2: in_ready is low while the 16-entry input FIFO is full, and also from the cycle after an accepted go strobe until the final block is taken. With block output stalled, exactly 32 words are accepted (16 held for assembly plus 16 queued) before in_ready drops.
- R3: tail_bits gives the number of valid bits in the final word, with 0 meaning all 32. When fewer than 32 bits are valid, the final word keeps its top tail_bits bits, has a one at bit 31-tail_bits, and has zeros below that.
- R4: When the word holding the padding one bit is word 13 or earlier, a single final block is emitted with blk_last = 1. All words after the one bit are zero, except words 14 and 15, which hold the length.
- R5: When the padding one bit would fall in word 14, word 15 or beyond the block, the current block is emitted zero-filled with blk_last = 0. It is followed by a block with blk_last = 1 whose words are all zero except words 14 and 15 (the length). Word 0 of that block is 0x80000000 only when the message filled the previous block exactly.
- R6: The length field equals 32 × (words − 1) + valid bits of the final word. A go strobe with no words gives length 0 and a single block whose only set bit is bit 511.
- R7: With md5_sel = 0 at the go strobe, word 14 holds length[63:32] and word 15 holds length[31:0]. With md5_sel = 1, the length goes out least significant byte first: word 14 = {L[7:0], L[15:8], L[23:16], L[31:24]} and word 15 = {L[39:32], L[47:40], L[55:48], L[63:56]}.
- R8: A word accepted in the same cycle as the go strobe is counted as the final word. A go strobe raised while padding is still pending is ignored, and its tail_bits and md5_sel have no effect on the output.
- R9: While blk_valid is high and blk_ready is low, blk_valid, blk_data and blk_last hold steady.
- R10: Once the final block is accepted, the length counter and control state return to idle and in_ready rises, so the next message is padded with its own length only.
- R11: A block completed by the sixteenth word is not offered until a further word is queued or the go strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Message word offered |
| in_ready | output | 1 | Message word can be taken |
| in_data | input | 32 | Message word, bit 31 first |
| pad_go | input | 1 | One-cycle strobe: message complete, start final padding |
| tail_bits | input | 5 | Valid bits in the final word (0 means 32), sampled with pad_go |
| md5_sel | input | 1 | Length byte order, 1 = least significant byte first, sampled with pad_go |
| blk_valid | output | 1 | Output block offered |
| blk_ready | input | 1 | Downstream takes the block |
| blk_data | output | 512 | Output block, word 0 in the top bits |
| blk_last | output | 1 | Marks the final block of a message |

## Verification
Two events can land in the same cycle: the acceptance of the final message word and the go strobe. The bench provokes this by raising in_valid and pad_go together on one edge. It judges the outcome by comparing the emitted block against a reference in which that word is the trimmed final word and counts toward the length. The same scenario then holds the output stalled and fires a second go strobe with different tail bits and byte order. The emitted block must still match the first strobe's parameters.

// File: rtl/pad_pkg.sv
package pad_pkg;

   // Assembly state of the block builder
   typedef enum logic [1:0] {
      AS_FILL = 2'd0,   // gathering message words
      AS_PAD  = 2'd1,   // one cycle: apply final padding to the held block
      AS_OUT  = 2'd2    // offering a block downstream
   } asm_state_e;

endpackage

// File: rtl/pad_fifo.sv
module pad_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] pop_data,
   output logic             full,
   output logic             nempty
);
   localparam int AW = $clog2(DEPTH);

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [AW:0]      wp_q, rp_q;

   assign full     = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
   assign nempty   = (wp_q != rp_q);
   assign pop_data = mem_q[rp_q[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + 1'b1;
         if (pop)  rp_q <= rp_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem_q[wp_q[AW-1:0]] <= push_data;
   end

   AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);    // R2
   AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> nempty);    // R1

endmodule

// File: rtl/msg_len_track.sv
module msg_len_track #(
   parameter int WORD_W = 32,
   parameter int LEN_W  = 64,
   localparam int TBW   = $clog2(WORD_W),
   localparam int NBW   = TBW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             word_acc,
   input  logic             go_acc,
   input  logic [TBW-1:0]   tail_bits,
   input  logic             md5_in,
   input  logic             done,
   output logic             pend,
   output logic [LEN_W-1:0] len_q,
   output logic [NBW-1:0]   nb_q,
   output logic             md5_q
);
   logic [LEN_W-1:0] bitcnt_q;
   logic             nonempty_q;
   logic             pend_q;
   logic [NBW-1:0]   nb_eff;
   logic [LEN_W-1:0] total;
   logic             any_word;

   always_comb begin
      nb_eff   = (tail_bits == '0) ? NBW'(WORD_W) : {1'b0, tail_bits};
      total    = bitcnt_q + (word_acc ? LEN_W'(WORD_W) : '0);
      any_word = nonempty_q | word_acc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bitcnt_q   <= '0;
         nonempty_q <= 1'b0;
         pend_q     <= 1'b0;
         len_q      <= '0;
         nb_q       <= NBW'(WORD_W);
         md5_q      <= 1'b0;
      end else if (done) begin
         bitcnt_q   <= '0;
         nonempty_q <= 1'b0;
         pend_q     <= 1'b0;
      end else begin
         if (word_acc) begin
            bitcnt_q   <= total;
            nonempty_q <= 1'b1;
         end
         if (go_acc) begin
            pend_q <= 1'b1;
            len_q  <= any_word ? (total - LEN_W'(WORD_W) + LEN_W'(nb_eff)) : '0;
            nb_q   <= nb_eff;
            md5_q  <= md5_in;
         end
      end
   end

   assign pend = pend_q;

   AST_CLEAR_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (bitcnt_q == '0) && !pend_q);    // R10

endmodule

// File: rtl/len_encode.sv
module len_encode #(
   parameter int WORD_W = 32,
   parameter int LEN_W  = 64,
   parameter bit MD5_EN = 1'b1
) (
   input  logic [LEN_W-1:0]  len,
   input  logic              md5,
   output logic [WORD_W-1:0] w_first,
   output logic [WORD_W-1:0] w_second
);
   localparam int NB = WORD_W / 8;

   if (MD5_EN) begin : g_both
      logic [WORD_W-1:0] sw_lo, sw_hi;
      for (genvar b = 0; b < NB; b++) begin : g_byte
         assign sw_lo[(WORD_W-8-8*b) +: 8] = len[8*b +: 8];
         assign sw_hi[(WORD_W-8-8*b) +: 8] = len[WORD_W + 8*b +: 8];
      end
      assign w_first  = md5 ? sw_lo : len[LEN_W-1:WORD_W];
      assign w_second = md5 ? sw_hi : len[WORD_W-1:0];
   end else begin : g_big_only
      logic unused_md5;
      assign unused_md5 = md5;
      assign w_first  = len[LEN_W-1:WORD_W];
      assign w_second = len[WORD_W-1:0];
   end

endmodule

// File: rtl/blk_assembler.sv
module blk_assembler
   import pad_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int BLK_WORDS = 16,
   localparam int NBW      = $clog2(WORD_W) + 1,
   localparam int CW       = $clog2(BLK_WORDS + 1),
   localparam int IW       = $clog2(BLK_WORDS),
   localparam int BLK_W    = WORD_W * BLK_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] fifo_data,
   input  logic              fifo_nempty,
   output logic              fifo_pop,
   input  logic              fin_pend,
   input  logic [NBW-1:0]    fin_nb,
   input  logic [WORD_W-1:0] len_first,
   input  logic [WORD_W-1:0] len_second,
   output logic              blk_valid,
   input  logic              blk_ready,
   output logic [BLK_W-1:0]  blk_data,
   output logic              blk_last,
   output logic              msg_done
);
   localparam logic [WORD_W-1:0] TOP_BIT = {1'b1, {(WORD_W-1){1'b0}}};

   asm_state_e        st_q;
   logic [WORD_W-1:0] words_q [BLK_WORDS];
   logic [WORD_W-1:0] pad_w   [BLK_WORDS];
   logic [CW-1:0]     wcnt_q;
   logic              last_q, tail_pend_q, tail_one_q;

   // Padding geometry for the held partial block
   logic              masked, fits;
   logic [CW-1:0]     one_pos;
   logic [WORD_W-1:0] keep_m, one_m;

   always_comb begin
      masked  = (wcnt_q != '0) && (fin_nb < NBW'(WORD_W));
      one_pos = masked ? (wcnt_q - 1'b1) : wcnt_q;
      fits    = (one_pos <= CW'(BLK_WORDS - 3));
      keep_m  = ~({WORD_W{1'b1}} >> fin_nb);
      one_m   = TOP_BIT >> fin_nb;
   end

   for (genvar i = 0; i < BLK_WORDS; i++) begin : g_pad
      always_comb begin
         if (CW'(i) < one_pos)
            pad_w[i] = words_q[i];
         else if (CW'(i) == one_pos)
            pad_w[i] = masked ? ((words_q[i] & keep_m) | one_m) : TOP_BIT;
         else if (fits && (i == BLK_WORDS - 2))
            pad_w[i] = len_first;
         else if (fits && (i == BLK_WORDS - 1))
            pad_w[i] = len_second;
         else
            pad_w[i] = '0;
      end
      assign blk_data[(BLK_WORDS-1-i)*WORD_W +: WORD_W] = words_q[i];
   end

   assign fifo_pop  = (st_q == AS_FILL) && fifo_nempty && (wcnt_q < CW'(BLK_WORDS));
   assign blk_valid = (st_q == AS_OUT);
   assign blk_last  = last_q;
   assign msg_done  = (st_q == AS_OUT) && blk_ready && last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= AS_FILL;
         wcnt_q      <= '0;
         last_q      <= 1'b0;
         tail_pend_q <= 1'b0;
         tail_one_q  <= 1'b0;
      end else begin
         case (st_q)
            AS_FILL: begin
               if (fifo_pop)
                  wcnt_q <= wcnt_q + 1'b1;
               if ((wcnt_q == CW'(BLK_WORDS)) && fifo_nempty) begin
                  st_q   <= AS_OUT;
                  last_q <= 1'b0;
               end else if (fin_pend && !fifo_nempty) begin
                  st_q <= AS_PAD;
               end
            end
            AS_PAD: begin
               last_q      <= fits;
               tail_pend_q <= !fits;
               tail_one_q  <= (one_pos == CW'(BLK_WORDS));
               st_q        <= AS_OUT;
            end
            AS_OUT: begin
               if (blk_ready) begin
                  if (!last_q && tail_pend_q) begin
                     last_q      <= 1'b1;
                     tail_pend_q <= 1'b0;
                  end else begin
                     last_q <= 1'b0;
                     wcnt_q <= '0;
                     st_q   <= AS_FILL;
                  end
               end
            end
            default: st_q <= AS_FILL;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (fifo_pop)
         words_q[wcnt_q[IW-1:0]] <= fifo_data;
      else if (st_q == AS_PAD) begin
         for (int i = 0; i < BLK_WORDS; i++) words_q[i] <= pad_w[i];
      end else if ((st_q == AS_OUT) && blk_ready && !last_q && tail_pend_q) begin
         for (int i = 0; i < BLK_WORDS; i++) begin
            if (i == 0)                   words_q[i] <= tail_one_q ? TOP_BIT : '0;
            else if (i == BLK_WORDS - 2)  words_q[i] <= len_first;
            else if (i == BLK_WORDS - 1)  words_q[i] <= len_second;
            else                          words_q[i] <= '0;
         end
      end
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid && !blk_ready |=> blk_valid && $stable(blk_data) && $stable(blk_last));  // R9
   AST_LAST_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid && blk_last |-> fin_pend);  // R4
   AST_TAIL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid && blk_ready && !blk_last && tail_pend_q |=> blk_valid && blk_last);  // R5
   AST_FULL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == AS_FILL) && !fifo_nempty && !fin_pend |=> !blk_valid);  // R11

endmodule

// File: rtl/hash_pad_frontend.sv
module hash_pad_frontend #(
   parameter int WORD_W     = 32,
   parameter int BLK_WORDS  = 16,
   parameter int LEN_W      = 64,
   parameter int FIFO_DEPTH = 16,
   parameter bit MD5_EN     = 1'b1,
   localparam int TBW       = $clog2(WORD_W),
   localparam int NBW       = TBW + 1,
   localparam int BLK_W     = WORD_W * BLK_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_data,
   input  logic              pad_go,
   input  logic [TBW-1:0]    tail_bits,
   input  logic              md5_sel,
   output logic              blk_valid,
   input  logic              blk_ready,
   output logic [BLK_W-1:0]  blk_data,
   output logic              blk_last
);
   // Elaboration-time parameter checks
   initial begin
      if (LEN_W != 2 * WORD_W)                 $fatal(1, "length must span two words");
      if ((WORD_W % 8) != 0 || WORD_W < 16)    $fatal(1, "word width must be whole bytes");
      if (BLK_WORDS < 4 || (BLK_WORDS & (BLK_WORDS - 1)) != 0)
                                               $fatal(1, "block words must be a power of two");
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0)
                                               $fatal(1, "fifo depth must be a power of two");
   end

   logic              fifo_full, fifo_nempty, fifo_pop;
   logic [WORD_W-1:0] fifo_data;
   logic              word_acc, go_acc, pend, done;
   logic [LEN_W-1:0]  len_q;
   logic [NBW-1:0]    nb_q;
   logic              md5_q;
   logic [WORD_W-1:0] len_first, len_second;

   assign in_ready = !fifo_full && !pend;
   assign word_acc = in_valid && in_ready;
   assign go_acc   = pad_go && !pend;

   pad_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (word_acc),
      .push_data (in_data),
      .pop       (fifo_pop),
      .pop_data  (fifo_data),
      .full      (fifo_full),
      .nempty    (fifo_nempty)
   );

   msg_len_track #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_len (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_acc  (word_acc),
      .go_acc    (go_acc),
      .tail_bits (tail_bits),
      .md5_in    (md5_sel),
      .done      (done),
      .pend      (pend),
      .len_q     (len_q),
      .nb_q      (nb_q),
      .md5_q     (md5_q)
   );

   len_encode #(.WORD_W(WORD_W), .LEN_W(LEN_W), .MD5_EN(MD5_EN)) u_enc (
      .len      (len_q),
      .md5      (md5_q),
      .w_first  (len_first),
      .w_second (len_second)
   );

   blk_assembler #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)) u_asm (
      .clk         (clk),
      .rst_n       (rst_n),
      .fifo_data   (fifo_data),
      .fifo_nempty (fifo_nempty),
      .fifo_pop    (fifo_pop),
      .fin_pend    (pend),
      .fin_nb      (nb_q),
      .len_first   (len_first),
      .len_second  (len_second),
      .blk_valid   (blk_valid),
      .blk_ready   (blk_ready),
      .blk_data    (blk_data),
      .blk_last    (blk_last),
      .msg_done    (done)
   );

   AST_GO_IGNORED_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      pend && pad_go |=> $stable(len_q) && $stable(nb_q) && $stable(md5_q));  // R8
   AST_READY_BACK_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid && blk_ready && blk_last |=> !pend);  // R10

endmodule

// File: tb/tb_hash_pad_frontend.sv
`timescale 1ns/1ps
module tb_hash_pad_frontend;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [31:0]  in_data = '0;
   logic         pad_go = 1'b0;
   logic [4:0]   tail_bits = '0;
   logic         md5_sel = 1'b0;
   logic         blk_valid;
   logic         blk_ready = 1'b0;
   logic [511:0] blk_data;
   logic         blk_last;

   always #5 clk = ~clk;

   hash_pad_frontend dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .pad_go(pad_go), .tail_bits(tail_bits), .md5_sel(md5_sel),
      .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_data(blk_data), .blk_last(blk_last)
   );

   int checks = 0;
   int fails  = 0;

   logic [31:0]  msg_q[$];
   logic [511:0] exp_q[$];
   logic [511:0] got_q[$];
   bit           got_last[$];

   bit           stall_en = 0;
   bit           hold_low = 0;
   logic [7:0]   lfsr = 8'h5B;
   bit           prev_wait = 0;
   logic [511:0] prev_data = '0;
   bit           prev_last = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [511:0] act, input logic [511:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
      end
   endtask

   // Output side: choose ready for the coming edge, record transfers, check holding
   always @(negedge clk) begin
      bit r;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      r = hold_low ? 1'b0 : (stall_en ? lfsr[0] : 1'b1);
      if (prev_wait)
         chk(blk_valid && blk_data == prev_data && blk_last == prev_last,
             "R9", "stalled block changed", blk_data, prev_data);
      blk_ready = r;
      if (blk_valid && r) begin
         got_q.push_back(blk_data);
         got_last.push_back(blk_last);
      end
      prev_wait = blk_valid && !r;
      prev_data = blk_data;
      prev_last = blk_last;
   end

   task automatic prep_msg(input int n, input int seed);
      msg_q.delete();
      got_q.delete();
      got_last.delete();
      for (int k = 0; k < n; k++)
         msg_q.push_back((32'(seed) * 32'h9E3779B9) ^ (32'(k) * 32'h01000193) ^ 32'h5A5A0F0F);
   endtask

   // Reference padding built from the requirements
   task automatic make_expected(input int nb, input bit md5);
      logic [31:0] w[$];
      logic [63:0] len;
      int          eff;
      int          n;
      logic [511:0] blk;
      n   = msg_q.size();
      eff = (nb == 0) ? 32 : nb;
      len = (n == 0) ? 64'd0 : 64'(32 * (n - 1) + eff);
      exp_q.delete();
      foreach (msg_q[k]) w.push_back(msg_q[k]);
      if (n > 0 && eff < 32)
         w[n-1] = (w[n-1] & ~(32'hFFFF_FFFF >> eff)) | (32'h8000_0000 >> eff);
      else
         w.push_back(32'h8000_0000);
      while ((w.size() % 16) != 14) w.push_back(32'h0);
      if (md5) begin
         w.push_back({len[7:0], len[15:8], len[23:16], len[31:24]});
         w.push_back({len[39:32], len[47:40], len[55:48], len[63:56]});
      end else begin
         w.push_back(len[63:32]);
         w.push_back(len[31:0]);
      end
      for (int b = 0; b < w.size() / 16; b++) begin
         for (int j = 0; j < 16; j++) blk[511 - 32*j -: 32] = w[16*b + j];
         exp_q.push_back(blk);
      end
   endtask

   task automatic push_word(input logic [31:0] d);
      in_valid = 1'b1;
      in_data  = d;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic go_pulse(input int nb, input bit md5);
      pad_go    = 1'b1;
      tail_bits = 5'(nb);
      md5_sel   = md5;
      @(negedge clk);
      pad_go = 1'b0;
   endtask

   task automatic wait_compare(input string req);
      int t = 0;
      while (got_q.size() < exp_q.size() && t < 3000) begin
         @(negedge clk);
         t++;
      end
      repeat (6) @(negedge clk);
      chk(got_q.size() == exp_q.size(), req, "block count",
          512'(got_q.size()), 512'(exp_q.size()));
      for (int b = 0; b < exp_q.size() && b < got_q.size(); b++) begin
         chk(got_q[b] == exp_q[b], req, $sformatf("block %0d data", b), got_q[b], exp_q[b]);
         chk(got_last[b] == (b == exp_q.size() - 1), req, $sformatf("block %0d last", b),
             512'(got_last[b]), 512'(b == exp_q.size() - 1));
      end
      chk(in_ready == 1'b1, "R10", "in_ready after final block", 512'(in_ready), 512'd1);
   endtask

   // Whole message: words, optional pause, go strobe, compare
   task automatic run_msg(input int n, input int nb, input bit md5, input bit stall,
                          input int seed, input string req);
      prep_msg(n, seed);
      make_expected(nb, md5);
      stall_en = stall;
      foreach (msg_q[k]) push_word(msg_q[k]);
      if (n > 0 && (n % 16) == 0) begin
         repeat (30) @(negedge clk);
         chk(blk_valid == 1'b0, "R11", "full block offered before go", 512'(blk_valid), 512'd0);
      end
      go_pulse(nb, md5);
      wait_compare(req);
      stall_en = 0;
   endtask

   task automatic t_reset();
      chk(in_ready == 1'b1, "R2", "in_ready after reset", 512'(in_ready), 512'd1);
      chk(blk_valid == 1'b0, "R9", "blk_valid after reset", 512'(blk_valid), 512'd0);
   endtask

   task automatic t_fifo_full();
      int acc = 0;
      prep_msg(40, 77);
      make_expected(0, 1'b0);
      hold_low = 1;
      for (int c = 0; c < 80; c++) begin
         bit take;
         in_valid = (acc < 40);
         in_data  = msg_q[acc < 40 ? acc : 39];
         take     = in_valid && in_ready;
         @(negedge clk);
         if (take) acc++;
      end
      in_valid = 1'b0;
      chk(acc == 32, "R2", "words taken while stalled", 512'(acc), 512'd32);
      chk(in_ready == 1'b0, "R2", "in_ready with fifo full", 512'(in_ready), 512'd0);
      hold_low = 0;
      for (int k = 32; k < 40; k++) push_word(msg_q[k]);
      go_pulse(0, 1'b0);
      wait_compare("R2 R1");
   endtask

   task automatic t_same_cycle();
      prep_msg(6, 91);
      make_expected(9, 1'b0);
      for (int k = 0; k < 5; k++) push_word(msg_q[k]);
      hold_low = 1;
      while (!in_ready) @(negedge clk);
      in_valid  = 1'b1;
      in_data   = msg_q[5];
      pad_go    = 1'b1;
      tail_bits = 5'd9;
      md5_sel   = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      pad_go   = 1'b0;
      chk(in_ready == 1'b0, "R8", "in_ready after go", 512'(in_ready), 512'd0);
      repeat (3) @(negedge clk);
      go_pulse(3, 1'b1);
      repeat (4) @(negedge clk);
      hold_low = 0;
      wait_compare("R8");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      run_msg(3,  8,  1'b0, 1'b0, 1,  "R3 R4 R6");
      run_msg(0,  0,  1'b0, 1'b0, 2,  "R6");
      run_msg(13, 5,  1'b0, 1'b0, 3,  "R4");
      run_msg(14, 31, 1'b0, 1'b0, 4,  "R4 R3");
      run_msg(14, 0,  1'b0, 1'b0, 5,  "R5");
      run_msg(15, 12, 1'b0, 1'b0, 6,  "R5 R3");
      run_msg(16, 0,  1'b0, 1'b0, 7,  "R11 R5");
      run_msg(16, 7,  1'b0, 1'b0, 8,  "R11 R5");
      run_msg(5,  17, 1'b1, 1'b0, 9,  "R7");
      run_msg(14, 0,  1'b1, 1'b0, 10, "R7 R5");
      run_msg(40, 20, 1'b0, 1'b1, 11, "R1 R9");
      run_msg(2,  0,  1'b0, 1'b1, 12, "R10");
      t_fifo_full();
      t_same_cycle();
      run_msg(1,  1,  1'b1, 1'b0, 13, "R10 R6");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule